// File: doc/BRIEF.md
# Zero-Substitution Decoder for Dual-Rail Line Data

This block sits after the slicer of a primary-rate receive path. It takes recovered bipolar data as two rails, positive and negative, with one bit per clock. It delays the stream by eight bits and drives the same two rails out. While the stream is held in the delay line, the block checks it for the fill patterns that a line encoder inserts in place of long runs of zeros. When removal is enabled, it overwrites each fill pattern it recognises with zeros on both rails. It also raises a violation flag in the same cycle as any outgoing bit that breaks the alternating-polarity rule.

A mode input selects between two rule sets. With the mode low, the block uses the eight-bit substitution, which carries two deliberate violations. With the mode high, it uses the four-bit substitution, which carries one deliberate violation. When the eight-bit rules are in force and removal is on, the deliberate violations inside a removed pattern are not reported. When the four-bit rules are in force and removal is on, the flag is held low.

Top module: `zs_decoder`

## Requirements
- R1: While reset (active low) is asserted, pos_out, neg_out and bpv_out are all low.
- R2: With zs_en low, pos_out and neg_out repeat pos_in and neg_in exactly eight clocks later, in either mode.
- R3: With mode_hdb3 low and zs_en high, each eight-bit group 0,0,0,p,-p,0,-p,p is output as eight zero bits on both rails. The group is written oldest bit first, and p is the polarity of the last single-rail pulse before the group.
- R4: With mode_hdb3 high and zs_en high, a single-rail pulse with the same polarity as the previous pulse, preceded by three zero bits, is output as four zero bits.
- R5: With mode_hdb3 high and zs_en high, a group made of any bit followed by 0,0 and then a same-polarity pulse is output as four zero bits. This covers the pulse-zero-zero-pulse form.
- R6: A single-rail pulse with the same polarity as the last preceding single-rail pulse is a violation. bpv_out is high for exactly the one cycle in which that bit is on the outputs. The first pulse after reset is never a violation.
- R7: A bit with both rails high is a violation, and bpv_out is high for that bit. Such a bit does not change the reference polarity.
- R8: With mode_hdb3 low and zs_en high, the two violations inside a removed eight-bit group are not flagged.
- R9: With mode_hdb3 high and zs_en high, bpv_out stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pos_in | input | 1 | Positive rail in |
| neg_in | input | 1 | Negative rail in |
| mode_hdb3 | input | 1 | 0: eight-bit substitution rules, 1: four-bit rules |
| zs_en | input | 1 | 1: remove recognised substitution groups |
| pos_out | output | 1 | Positive rail out, eight bits late |
| neg_out | output | 1 | Negative rail out, eight bits late |
| bpv_out | output | 1 | Violation flag aligned with the output bit |

## Verification
Violation flagging and pattern removal can act on the same bits in the same cycle. A removed eight-bit group must clear its own violation flags, while a genuine violation next to the group must still be flagged. The bench provokes this with random streams in all four mode settings. These streams mix stray same-polarity pulses and both-rail bits with complete substitution groups placed directly against them. A behavioural model works only in signed symbols and reference polarities, and it judges both rails and the flag on every clock.

// File: rtl/zs_decoder.sv
module zs_decoder (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_in,
  input  logic neg_in,
  input  logic mode_hdb3,
  input  logic zs_en,
  output logic pos_out,
  output logic neg_out,
  output logic bpv_out
);
  localparam int DEPTH = 8;

  logic [DEPTH-1:0] sp, sn, sv;
  logic last_neg, seen;

  wire single  = pos_in ^ neg_in;
  wire viol_in = (pos_in & neg_in) | (single & seen & (neg_in == last_neg));
  wire quiet   = mode_hdb3 & zs_en;

  wire [DEPTH-1:0] wp = {sp[DEPTH-2:0], pos_in};
  wire [DEPTH-1:0] wn = {sn[DEPTH-2:0], neg_in};
  wire [DEPTH-1:0] wv = {sv[DEPTH-2:0], viol_in};
  wire [DEPTH-1:0] wz = ~(wp | wn);
  wire [DEPTH-1:0] ws = wp ^ wn;

  wire hit8 = ~mode_hdb3 & wz[7] & wz[6] & wz[5] & wz[2]
            & ws[4] & ws[3] & ws[1] & ws[0]
            & wv[4] & ~wv[3] & wv[1] & ~wv[0];
  wire hit4 = mode_hdb3 & single & viol_in & wz[1] & wz[2];

  logic [DEPTH-1:0] clr;
  always_comb begin
    clr = '0;
    if (zs_en && hit8) clr = '1;
    else if (zs_en && hit4) clr = {{(DEPTH-4){1'b0}}, 4'hF};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      sn <= '0;
      sv <= '0;
      last_neg <= 1'b0;
      seen <= 1'b0;
    end else begin
      sp <= wp & ~clr;
      sn <= wn & ~clr;
      sv <= {sv[DEPTH-2:0], viol_in & ~quiet} & ~clr;
      if (single) begin
        last_neg <= neg_in;
        seen <= 1'b1;
      end
    end
  end

  assign pos_out = sp[DEPTH-1];
  assign neg_out = sn[DEPTH-1];
  assign bpv_out = sv[DEPTH-1];
endmodule

// File: rtl/zs_decoder_chk.sv
module zs_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic pos_in,
  input logic neg_in,
  input logic mode_hdb3,
  input logic zs_en,
  input logic pos_out,
  input logic neg_out,
  input logic bpv_out
);
  logic [3:0] low_cnt, quiet_cnt, stab_cnt;
  logic [1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      quiet_cnt <= '0;
      stab_cnt <= '0;
      cfg_q <= {mode_hdb3, zs_en};
    end else begin
      cfg_q <= {mode_hdb3, zs_en};
      low_cnt <= zs_en ? 4'd0 : (low_cnt == 4'd15 ? low_cnt : low_cnt + 4'd1);
      quiet_cnt <= (mode_hdb3 && zs_en) ? (quiet_cnt == 4'd15 ? quiet_cnt : quiet_cnt + 4'd1) : 4'd0;
      stab_cnt <= (cfg_q != {mode_hdb3, zs_en}) ? 4'd0 : (stab_cnt == 4'd15 ? stab_cnt : stab_cnt + 4'd1);
    end
  end

  p_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt >= 4'd9) |-> (pos_out == $past(pos_in, 8) && neg_out == $past(neg_in, 8)));

  p_flag_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_out |-> (pos_out || neg_out));

  p_both_rails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stab_cnt >= 4'd9 && !(mode_hdb3 && zs_en) && pos_out && neg_out) |-> bpv_out);

  p_quiet_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt >= 4'd9) |-> !bpv_out);
endmodule

bind zs_decoder zs_decoder_chk u_chk (.*);

// File: tb/zs_decoder_tb.sv
module zs_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos_in = 1'b0, neg_in = 1'b0, mode_hdb3 = 1'b0, zs_en = 1'b0;
  logic pos_out, neg_out, bpv_out;

  int checks = 0, fails = 0;
  string req = "R1";
  bit finished = 1'b0;

  int sym [0:4095];
  bit flg [0:4095];
  int pp  [0:4095];
  int n = 0;
  int lastp = 0;

  always #5 clk = ~clk;

  zs_decoder u_dut (.clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
    .mode_hdb3(mode_hdb3), .zs_en(zs_en), .pos_out(pos_out), .neg_out(neg_out), .bpv_out(bpv_out));

  task automatic compare(input bit ep, input bit en_, input bit ev);
    checks++;
    if (pos_out !== ep || neg_out !== en_ || bpv_out !== ev) begin
      fails++;
      $display("FAIL %s: got pos/neg/bpv %b%b%b expected %b%b%b at bit %0d",
               req, pos_out, neg_out, bpv_out, ep, en_, ev, n - 8);
    end
  endtask

  function automatic void model_push(input int s);
    pp[n] = lastp;
    flg[n] = (s == 2) || ((s == 1 || s == -1) && s == lastp);
    if (mode_hdb3 && zs_en) flg[n] = 1'b0;
    if (s == 1 || s == -1) lastp = s;
    sym[n] = s;
    if (zs_en && !mode_hdb3 && n >= 7) begin
      int r;
      r = pp[n-7];
      if (r != 0 && sym[n-7] == 0 && sym[n-6] == 0 && sym[n-5] == 0 && sym[n-4] == r &&
          sym[n-3] == -r && sym[n-2] == 0 && sym[n-1] == -r && sym[n] == r)
        for (int k = n - 7; k <= n; k++) begin sym[k] = 0; flg[k] = 1'b0; end
    end
    if (zs_en && mode_hdb3 && n >= 2) begin
      if ((s == 1 || s == -1) && s == pp[n] && sym[n-1] == 0 && sym[n-2] == 0)
        for (int k = (n >= 3 ? n - 3 : 0); k <= n; k++) begin sym[k] = 0; flg[k] = 1'b0; end
    end
    n++;
  endfunction

  task automatic send(input int s);
    pos_in = (s == 1 || s == 2);
    neg_in = (s == -1 || s == 2);
    model_push(s);
    @(posedge clk);
    @(negedge clk);
    if (n >= 8) compare(sym[n-8] == 1 || sym[n-8] == 2, sym[n-8] == -1 || sym[n-8] == 2, flg[n-8]);
    else compare(1'b0, 1'b0, 1'b0);
  endtask

  task automatic restart(input bit m, input bit e, input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    pos_in = 1'b1;
    neg_in = 1'b1;
    mode_hdb3 = m;
    zs_en = e;
    n = 0;
    lastp = 0;
    repeat (2) @(negedge clk);
    req = "R1";
    compare(1'b0, 1'b0, 1'b0);
    pos_in = 1'b0;
    neg_in = 1'b0;
    rst_n = 1'b1;
    req = tag;
  endtask

  task automatic flush;
    for (int i = 0; i < 10; i++) send(0);
  endtask

  task automatic word8;
    int r;
    if (lastp == 0) send(1);
    r = lastp;
    send(0); send(0); send(0); send(r); send(-r); send(0); send(-r); send(r);
  endtask

  task automatic word4(input bit with_b);
    int r;
    if (lastp == 0) send(1);
    if (with_b) begin r = -lastp; send(r); send(0); send(0); send(r); end
    else begin r = lastp; send(0); send(0); send(0); send(r); end
  endtask

  task automatic random_run(input bit m, input bit e, input int len);
    restart(m, e, "R2/R3/R4/R6 mixed");
    for (int i = 0; i < len; i++) begin
      int x;
      x = $urandom % 16;
      if (x < 7) send(0);
      else if (x < 13) send(lastp == 1 ? -1 : 1);
      else if (x == 13) send(lastp == 0 ? 1 : lastp);
      else if (x == 14) send(2);
      else if (m) word4(($urandom % 2) == 1);
      else word8();
    end
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    restart(1'b0, 1'b0, "R2");
    for (int i = 0; i < 120; i++) send(($urandom % 2) ? (lastp == 1 ? -1 : 1) : 0);
    flush();

    restart(1'b0, 1'b1, "R3/R8");
    send(1); word8(); send(-1); send(0); word8(); send(1); word8();
    flush();

    restart(1'b0, 1'b0, "R6");
    send(1); word8(); send(1); send(0); send(1); send(-1); send(-1);
    flush();

    restart(1'b1, 1'b1, "R4/R9");
    send(1); word4(1'b0); send(-1); word4(1'b0);
    flush();

    restart(1'b1, 1'b1, "R5/R9");
    send(1); word4(1'b1); word4(1'b1); send(1); send(1);
    flush();

    restart(1'b1, 1'b0, "R2/R6");
    send(1); word4(1'b0); word4(1'b1);
    flush();

    restart(1'b0, 1'b0, "R7");
    send(2); send(1); send(2); send(-1); send(2); send(-1);
    flush();

    restart(1'b1, 1'b0, "R7");
    send(-1); send(2); send(1); send(2);
    flush();

    random_run(1'b0, 1'b0, 400);
    random_run(1'b0, 1'b1, 400);
    random_run(1'b1, 1'b0, 400);
    random_run(1'b1, 1'b1, 400);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule